// File: doc/BRIEF.md
# Predicated element loop sequencer

This block sits between instruction decode and the execution units. When decode hands it an instruction whose operands are tagged as vectors, it expands that one instruction into a run of element operations. There are VL elements, and each element is split into SUBVL sub-elements. For each of them it issues a set of operand register numbers to the execution side and waits for a completion before it moves on. The architectural PC is held until the block reports `done`, or until an exception ends the loop with `trap`.

The block keeps the loop offsets (an element index and a sub-element index) as state that lasts beyond one instruction. This lets a trapped loop resume at the exact sub-element that faulted, and lets a context restore load the offsets directly. A per-element predicate mask selects which elements run. Masked-out elements are either skipped or turned into zero-write requests. A fail-first mode cuts VL short at the first element whose result is zero.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset, VL reads 1, both offsets read 0, and `iss_valid`, `done` and `trap` are low.
- R2: A `vl_wr` pulse writes VL clamped to the range 1..MAXVL (a written 0 gives 1, anything above MAXVL gives MAXVL) and clears both offsets to 0.
- R3: After `start`, issues come in strict order: sub-elements 0..SUBVL-1 inside each element, elements ascending. `subvl_m1` encodes SUBVL-1. Exactly one issue is made per accepted `iss_valid`/`iss_ready` handshake, and `iss_valid` and its fields stay stable until accepted. The next issue waits for `cmp_valid`.
- R4: The operand register number is `base + elem*SUBVL + sub` modulo 2^REGW when the operand's vector flag is set (`vec_flags` bit 0 rd, bit 1 rs1, bit 2 rs2). It is `base` for every issue when the flag is clear.
- R5: With `zeroing`=0, an element whose `pred_mask` bit is clear is not issued and the element offset moves past it. This also holds with `ffirst`=1: such an element is never tested.
- R6: With `zeroing`=1, each sub-element of a masked-out element is issued with `iss_zero`=1. Enabled sub-elements are issued with `iss_zero`=0.
- R7: A completion with `cmp_exc`=1 pulses `trap`, ends the loop and leaves both offsets and VL unchanged. The next `start` resumes at that same element and sub-element.
- R8: When the last sub-element of element VL-1 completes without an exception, `done` pulses, both offsets return to 0 and VL is unchanged. This also applies when the last element is skipped under R5.
- R9: With `ffirst`=1, a completion with `cmp_zero`=1 at element index i>0 sets VL to i, clears both offsets and pulses `done`. At element 0 a zero result does not truncate.
- R10: With `ffirst`=1 and `zeroing`=1, a masked-out element at index i>0 sets VL to i, clears the offsets and pulses `done` without issuing. At element 0 it is issued as a zero write.
- R11: An `offs_ld` pulse loads the element offset clamped to VL-1 and loads the sub offset as given. At `start` the sub offset is clamped to SUBVL-1, and issuing begins from the stored offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vl_wr | input | 1 | Write VL, clear offsets |
| vl_wdata | input | VLW | VL value to write |
| offs_ld | input | 1 | Load stored offsets |
| offs_elem_in | input | IDXW | Element offset to load |
| offs_sub_in | input | 2 | Sub-element offset to load |
| start | input | 1 | Begin a loop (when idle) |
| subvl_m1 | input | 2 | SUBVL minus one |
| vec_flags | input | 3 | Vector flags: bit0 rd, bit1 rs1, bit2 rs2 |
| base_rd | input | REGW | Destination base register |
| base_rs1 | input | REGW | Source 1 base register |
| base_rs2 | input | REGW | Source 2 base register |
| pred_mask | input | MAXVL | One predicate bit per element |
| zeroing | input | 1 | Masked-out elements write zero |
| ffirst | input | 1 | Fail-first mode |
| iss_valid | output | 1 | Issue valid |
| iss_ready | input | 1 | Issue accepted |
| iss_rd | output | REGW | Issued destination register |
| iss_rs1 | output | REGW | Issued source 1 register |
| iss_rs2 | output | REGW | Issued source 2 register |
| iss_elem | output | IDXW | Element index of this issue |
| iss_sub | output | 2 | Sub-element index of this issue |
| iss_zero | output | 1 | Issue is a zero-write request |
| cmp_valid | input | 1 | Completion of the outstanding issue |
| cmp_zero | input | 1 | Completed result was zero |
| cmp_exc | input | 1 | Completed operation raised an exception |
| vl_out | output | VLW | Current VL |
| elem_offs | output | IDXW | Stored element offset |
| sub_offs | output | 2 | Stored sub-element offset |
| trap | output | 1 | One-cycle pulse: loop ended by exception |
| done | output | 1 | One-cycle pulse: loop finished |

## Verification
The hardest state to reach is a resume in the middle of an element. That requires an exception on a sub-element other than the first, followed by a second `start` with the same configuration, so that issuing resumes at that element and sub-element. The stimulus gets there by injecting `cmp_exc` at a chosen issue index and restarting, and by loading offsets directly with a sub offset larger than the following SUBVL. Random runs also mix exceptions, zero results, VL rewrites and sparse masks. The offsets left by one run carry into the next, and the bench's model must track them the same way.

// File: rtl/elem_seq_pkg.sv
package elem_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_ISSUE,
    ST_WAIT
  } seq_state_t;

  localparam int NUM_OPND = 3;

endpackage

// File: rtl/elem_offs_regs.sv
module elem_offs_regs #(
  parameter int MAXVL = 16,
  parameter int VLW   = 5,
  parameter int IDXW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vl_wr,
  input  logic [VLW-1:0]  vl_wdata,
  input  logic            offs_ld,
  input  logic [IDXW-1:0] ld_elem,
  input  logic [1:0]      ld_sub,
  input  logic            start_clamp,
  input  logic [1:0]      sub_lim,
  input  logic            clr,
  input  logic            trunc,
  input  logic            skip,
  input  logic            step,
  output logic [VLW-1:0]  vl_q,
  output logic [IDXW-1:0] elem_q,
  output logic [1:0]      sub_q
);

  localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

  logic [VLW-1:0]  vl_clamped;
  logic [IDXW-1:0] elem_clamped;

  always_comb begin
    if (vl_wdata == '0)
      vl_clamped = VLW'(1);
    else if (vl_wdata > VL_MAX)
      vl_clamped = VL_MAX;
    else
      vl_clamped = vl_wdata;
  end

  always_comb begin
    if (VLW'(ld_elem) >= vl_q)
      elem_clamped = IDXW'(vl_q - VLW'(1));
    else
      elem_clamped = ld_elem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q   <= VLW'(1);
      elem_q <= '0;
      sub_q  <= '0;
    end else if (vl_wr) begin
      vl_q   <= vl_clamped;
      elem_q <= '0;
      sub_q  <= '0;
    end else if (offs_ld) begin
      elem_q <= elem_clamped;
      sub_q  <= ld_sub;
    end else if (clr) begin
      elem_q <= '0;
      sub_q  <= '0;
    end else if (trunc) begin
      vl_q   <= VLW'(elem_q);
      elem_q <= '0;
      sub_q  <= '0;
    end else if (skip) begin
      elem_q <= elem_q + IDXW'(1);
      sub_q  <= '0;
    end else if (step) begin
      if (sub_q < sub_lim) begin
        sub_q <= sub_q + 2'd1;
      end else begin
        sub_q  <= '0;
        elem_q <= elem_q + IDXW'(1);
      end
    end else if (start_clamp && (sub_q > sub_lim)) begin
      sub_q <= sub_lim;
    end
  end

  // R2: VL stays inside its legal range
  p_vl_range_r2: assert property (@(posedge clk) disable iff (rst)
    (vl_q >= VLW'(1)) && (vl_q <= VL_MAX));

  // R11: the element offset never reaches VL
  p_elem_lt_vl_r11: assert property (@(posedge clk) disable iff (rst)
    VLW'(elem_q) < vl_q);

endmodule

// File: rtl/elem_opnd_map.sv
module elem_opnd_map #(
  parameter int REGW = 7,
  parameter int LINW = 6
) (
  input  logic            vec,
  input  logic [REGW-1:0] base,
  input  logic [LINW-1:0] lin,
  output logic [REGW-1:0] reg_num
);

  always_comb begin
    if (vec)
      reg_num = base + REGW'(lin);
    else
      reg_num = base;
  end

endmodule

// File: rtl/elem_seq_ctrl.sv
module elem_seq_ctrl
  import elem_seq_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int REGW  = 7,
  parameter int VLW   = 5,
  parameter int IDXW  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               subvl_m1,
  input  logic [2:0]               vec_flags,
  input  logic [REGW-1:0]          base_rd,
  input  logic [REGW-1:0]          base_rs1,
  input  logic [REGW-1:0]          base_rs2,
  input  logic [MAXVL-1:0]         pred_mask,
  input  logic                     zeroing,
  input  logic                     ffirst,
  input  logic                     iss_ready,
  input  logic                     cmp_valid,
  input  logic                     cmp_zero,
  input  logic                     cmp_exc,
  input  logic [VLW-1:0]           vl_q,
  input  logic [IDXW-1:0]          elem_q,
  input  logic [1:0]               sub_q,
  input  logic [NUM_OPND*REGW-1:0] map_num,
  output logic [1:0]               sub_lim,
  output logic [2:0]               vec_q,
  output logic [NUM_OPND*REGW-1:0] base_q,
  output logic                     iss_valid,
  output logic [REGW-1:0]          iss_rd,
  output logic [REGW-1:0]          iss_rs1,
  output logic [REGW-1:0]          iss_rs2,
  output logic [IDXW-1:0]          iss_elem,
  output logic [1:0]               iss_sub,
  output logic                     iss_zero,
  output logic                     start_clamp,
  output logic                     clr,
  output logic                     trunc,
  output logic                     skip,
  output logic                     step,
  output logic                     done,
  output logic                     trap
);

  seq_state_t       state;
  logic [1:0]       sub_m1_q;
  logic [MAXVL-1:0] mask_q;
  logic             zero_q;
  logic             ff_q;

  logic pbit;
  logic last_elem;
  logic last_sub;
  logic elem_nz;

  assign pbit      = mask_q[elem_q];
  assign last_elem = (VLW'(elem_q) == (vl_q - VLW'(1)));
  assign last_sub  = (sub_q == sub_m1_q);
  assign elem_nz   = (elem_q != '0);
  assign sub_lim   = (state == ST_IDLE) ? subvl_m1 : sub_m1_q;

  always_comb begin
    start_clamp = 1'b0;
    clr         = 1'b0;
    trunc       = 1'b0;
    skip        = 1'b0;
    step        = 1'b0;
    case (state)
      ST_IDLE: start_clamp = start;
      ST_EVAL: begin
        if (!pbit && !zero_q) begin
          if (last_elem) clr  = 1'b1;
          else           skip = 1'b1;
        end else if (!pbit && ff_q && elem_nz) begin
          trunc = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cmp_valid && !cmp_exc) begin
          if (ff_q && cmp_zero && elem_nz) trunc = 1'b1;
          else if (last_elem && last_sub)  clr   = 1'b1;
          else                             step  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sub_m1_q  <= '0;
      vec_q     <= '0;
      base_q    <= '0;
      mask_q    <= '0;
      zero_q    <= 1'b0;
      ff_q      <= 1'b0;
      iss_valid <= 1'b0;
      iss_rd    <= '0;
      iss_rs1   <= '0;
      iss_rs2   <= '0;
      iss_elem  <= '0;
      iss_sub   <= '0;
      iss_zero  <= 1'b0;
      done      <= 1'b0;
      trap      <= 1'b0;
    end else begin
      done <= 1'b0;
      trap <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            sub_m1_q <= subvl_m1;
            vec_q    <= vec_flags;
            base_q   <= {base_rs2, base_rs1, base_rd};
            mask_q   <= pred_mask;
            zero_q   <= zeroing;
            ff_q     <= ffirst;
            state    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (clr || trunc) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (!skip) begin
            iss_valid <= 1'b1;
            iss_rd    <= map_num[0*REGW +: REGW];
            iss_rs1   <= map_num[1*REGW +: REGW];
            iss_rs2   <= map_num[2*REGW +: REGW];
            iss_elem  <= elem_q;
            iss_sub   <= sub_q;
            iss_zero  <= !pbit;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (iss_ready) begin
            iss_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cmp_valid) begin
            if (cmp_exc) begin
              trap  <= 1'b1;
              state <= ST_IDLE;
            end else if (trunc || clr) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_EVAL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: an offered issue is held unchanged until it is accepted
  p_valid_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_rd) &&
      $stable(iss_rs1) && $stable(iss_rs2) && $stable(iss_elem) && $stable(iss_sub)));

  // R6: zero-write requests only come from masked-out elements in zeroing mode
  p_zero_req_r6: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_zero) |-> (zero_q && !mask_q[iss_elem]));

endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import elem_seq_pkg::*;
#(
  parameter  int MAXVL = 16,
  parameter  int REGW  = 7,
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int IDXW  = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vl_wr,
  input  logic [VLW-1:0]   vl_wdata,
  input  logic             offs_ld,
  input  logic [IDXW-1:0]  offs_elem_in,
  input  logic [1:0]       offs_sub_in,
  input  logic             start,
  input  logic [1:0]       subvl_m1,
  input  logic [2:0]       vec_flags,
  input  logic [REGW-1:0]  base_rd,
  input  logic [REGW-1:0]  base_rs1,
  input  logic [REGW-1:0]  base_rs2,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             zeroing,
  input  logic             ffirst,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [REGW-1:0]  iss_rd,
  output logic [REGW-1:0]  iss_rs1,
  output logic [REGW-1:0]  iss_rs2,
  output logic [IDXW-1:0]  iss_elem,
  output logic [1:0]       iss_sub,
  output logic             iss_zero,
  input  logic             cmp_valid,
  input  logic             cmp_zero,
  input  logic             cmp_exc,
  output logic [VLW-1:0]   vl_out,
  output logic [IDXW-1:0]  elem_offs,
  output logic [1:0]       sub_offs,
  output logic             trap,
  output logic             done
);

  localparam int LINW = IDXW + 2;

  logic [VLW-1:0]             vl_q;
  logic [IDXW-1:0]            elem_q;
  logic [1:0]                 sub_q;
  logic [1:0]                 sub_lim;
  logic [2:0]                 vec_q;
  logic [NUM_OPND*REGW-1:0]   base_q;
  logic [NUM_OPND*REGW-1:0]   map_num;
  logic                       start_clamp, clr, trunc, skip, step;
  logic [2:0]                 sub_cnt;
  logic [LINW-1:0]            lin;

  assign sub_cnt = {1'b0, sub_lim} + 3'd1;
  assign lin     = LINW'(elem_q) * LINW'(sub_cnt) + LINW'(sub_q);

  elem_offs_regs #(
    .MAXVL(MAXVL), .VLW(VLW), .IDXW(IDXW)
  ) u_offs (
    .clk(clk), .rst(rst),
    .vl_wr(vl_wr), .vl_wdata(vl_wdata),
    .offs_ld(offs_ld), .ld_elem(offs_elem_in), .ld_sub(offs_sub_in),
    .start_clamp(start_clamp), .sub_lim(sub_lim),
    .clr(clr), .trunc(trunc), .skip(skip), .step(step),
    .vl_q(vl_q), .elem_q(elem_q), .sub_q(sub_q)
  );

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    elem_opnd_map #(
      .REGW(REGW), .LINW(LINW)
    ) u_map (
      .vec(vec_q[g]),
      .base(base_q[g*REGW +: REGW]),
      .lin(lin),
      .reg_num(map_num[g*REGW +: REGW])
    );
  end

  elem_seq_ctrl #(
    .MAXVL(MAXVL), .REGW(REGW), .VLW(VLW), .IDXW(IDXW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .subvl_m1(subvl_m1), .vec_flags(vec_flags),
    .base_rd(base_rd), .base_rs1(base_rs1), .base_rs2(base_rs2),
    .pred_mask(pred_mask), .zeroing(zeroing), .ffirst(ffirst),
    .iss_ready(iss_ready), .cmp_valid(cmp_valid), .cmp_zero(cmp_zero), .cmp_exc(cmp_exc),
    .vl_q(vl_q), .elem_q(elem_q), .sub_q(sub_q), .map_num(map_num),
    .sub_lim(sub_lim), .vec_q(vec_q), .base_q(base_q),
    .iss_valid(iss_valid), .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
    .iss_elem(iss_elem), .iss_sub(iss_sub), .iss_zero(iss_zero),
    .start_clamp(start_clamp), .clr(clr), .trunc(trunc), .skip(skip), .step(step),
    .done(done), .trap(trap)
  );

  assign vl_out    = vl_q;
  assign elem_offs = elem_q;
  assign sub_offs  = sub_q;

  // R7: the cycle that reports a trap sees the offsets untouched
  p_trap_keeps_offs_r7: assert property (@(posedge clk) disable iff (rst)
    trap |-> ($stable(elem_offs) && $stable(sub_offs) && $stable(vl_out)));

  // R8: a finished loop leaves both offsets at zero
  p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ((elem_offs == '0) && (sub_offs == '0)));

endmodule

// File: tb/elem_loop_seq_tb_top.sv
`timescale 1ns/1ps
module elem_loop_seq_tb_top;

  localparam int MAXVL = 16;
  localparam int REGW  = 7;
  localparam int VLW   = 5;
  localparam int IDXW  = 4;
  localparam int NREG  = 1 << REGW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             vl_wr = 1'b0;
  logic [VLW-1:0]   vl_wdata = '0;
  logic             offs_ld = 1'b0;
  logic [IDXW-1:0]  offs_elem_in = '0;
  logic [1:0]       offs_sub_in = '0;
  logic             start = 1'b0;
  logic [1:0]       subvl_m1 = '0;
  logic [2:0]       vec_flags = '0;
  logic [REGW-1:0]  base_rd = '0, base_rs1 = '0, base_rs2 = '0;
  logic [MAXVL-1:0] pred_mask = '0;
  logic             zeroing = 1'b0, ffirst = 1'b0;
  logic             iss_valid, iss_ready = 1'b0;
  logic [REGW-1:0]  iss_rd, iss_rs1, iss_rs2;
  logic [IDXW-1:0]  iss_elem;
  logic [1:0]       iss_sub;
  logic             iss_zero;
  logic             cmp_valid = 1'b0, cmp_zero = 1'b0, cmp_exc = 1'b0;
  logic [VLW-1:0]   vl_out;
  logic [IDXW-1:0]  elem_offs;
  logic [1:0]       sub_offs;
  logic             trap, done;

  always #10 clk = ~clk;

  elem_loop_seq #(.MAXVL(MAXVL), .REGW(REGW)) dut_i (
    .clk(clk), .rst(rst), .vl_wr(vl_wr), .vl_wdata(vl_wdata),
    .offs_ld(offs_ld), .offs_elem_in(offs_elem_in), .offs_sub_in(offs_sub_in),
    .start(start), .subvl_m1(subvl_m1), .vec_flags(vec_flags),
    .base_rd(base_rd), .base_rs1(base_rs1), .base_rs2(base_rs2),
    .pred_mask(pred_mask), .zeroing(zeroing), .ffirst(ffirst),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
    .iss_elem(iss_elem), .iss_sub(iss_sub), .iss_zero(iss_zero),
    .cmp_valid(cmp_valid), .cmp_zero(cmp_zero), .cmp_exc(cmp_exc),
    .vl_out(vl_out), .elem_offs(elem_offs), .sub_offs(sub_offs),
    .trap(trap), .done(done)
  );

  int checks = 0;
  int errors = 0;

  // bench model state
  int tb_vl = 1;
  int tb_e  = 0;
  int tb_s  = 0;

  int exp_rd[64], exp_rs1[64], exp_rs2[64], exp_el[64], exp_sb[64];
  bit exp_z[64];
  int exp_n;
  bit exp_done, exp_trap;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int opnd_num(input bit vec, input int base, input int e, input int sv, input int s);
    if (vec) return (base + e * sv + s) % NREG;
    return base;
  endfunction

  task automatic build_expect(input int sv_m1, input bit [2:0] vf, input int brd, input int brs1,
                              input int brs2, input bit [15:0] mask, input bit zr, input bit ff,
                              input int exc_at, input int zero_at);
    int e, s, sv, n, k;
    bit fin;
    sv = sv_m1 + 1;
    e = tb_e;
    s = (tb_s > sv_m1) ? sv_m1 : tb_s;
    n = 0; fin = 0; exp_done = 0; exp_trap = 0;
    while (!fin) begin
      if (!mask[e] && !zr) begin
        if (e == tb_vl - 1) begin exp_done = 1; e = 0; s = 0; fin = 1; end
        else begin e++; s = 0; end
      end else if (!mask[e] && ff && e != 0) begin
        tb_vl = e; exp_done = 1; e = 0; s = 0; fin = 1;
      end else begin
        k = n;
        exp_el[k]  = e;
        exp_sb[k]  = s;
        exp_z[k]   = !mask[e];
        exp_rd[k]  = opnd_num(vf[0], brd,  e, sv, s);
        exp_rs1[k] = opnd_num(vf[1], brs1, e, sv, s);
        exp_rs2[k] = opnd_num(vf[2], brs2, e, sv, s);
        n++;
        if (k == exc_at) begin exp_trap = 1; fin = 1; end
        else if (ff && k == zero_at && e != 0) begin tb_vl = e; exp_done = 1; e = 0; s = 0; fin = 1; end
        else if (e == tb_vl - 1 && s == sv_m1) begin exp_done = 1; e = 0; s = 0; fin = 1; end
        else if (s < sv_m1) s++;
        else begin s = 0; e++; end
      end
    end
    exp_n = n; tb_e = e; tb_s = s;
  endtask

  task automatic check_state(input string tag);
    chk(tag, "vl_out", int'(vl_out), tb_vl);
    chk(tag, "elem_offs", int'(elem_offs), tb_e);
    chk(tag, "sub_offs", int'(sub_offs), tb_s);
  endtask

  task automatic set_vl(input int val, input string tag);
    @(negedge clk);
    vl_wr = 1'b1; vl_wdata = VLW'(val);
    @(negedge clk);
    vl_wr = 1'b0;
    tb_vl = (val == 0) ? 1 : ((val > MAXVL) ? MAXVL : val);
    tb_e = 0; tb_s = 0;
    check_state(tag);
  endtask

  task automatic load_offs(input int e, input int s, input string tag);
    @(negedge clk);
    offs_ld = 1'b1; offs_elem_in = IDXW'(e); offs_sub_in = 2'(s);
    @(negedge clk);
    offs_ld = 1'b0;
    tb_e = (e >= tb_vl) ? tb_vl - 1 : e;
    tb_s = s;
    check_state(tag);
  endtask

  task automatic run_instr(input string tag, input int sv_m1, input bit [2:0] vf, input int brd,
                           input int brs1, input int brs2, input bit [15:0] mask, input bit zr,
                           input bit ff, input int exc_at, input int zero_at);
    int got, cyc;
    bit fin;
    build_expect(sv_m1, vf, brd, brs1, brs2, mask, zr, ff, exc_at, zero_at);
    @(negedge clk);
    start = 1'b1; subvl_m1 = 2'(sv_m1); vec_flags = vf;
    base_rd = REGW'(brd); base_rs1 = REGW'(brs1); base_rs2 = REGW'(brs2);
    pred_mask = mask; zeroing = zr; ffirst = ff;
    @(negedge clk);
    start = 1'b0;
    got = 0; fin = 0; cyc = 0;
    while (!fin) begin
      if (done || trap) begin
        fin = 1;
      end else if (iss_valid) begin
        if (got >= exp_n) begin
          chk(tag, "extra issue", got, exp_n);
        end else begin
          chk(tag, "iss_elem", int'(iss_elem), exp_el[got]);
          chk(tag, "iss_sub", int'(iss_sub), exp_sb[got]);
          chk(tag, "iss_rd", int'(iss_rd), exp_rd[got]);
          chk(tag, "iss_rs1", int'(iss_rs1), exp_rs1[got]);
          chk(tag, "iss_rs2", int'(iss_rs2), exp_rs2[got]);
          chk(tag, "iss_zero", int'(iss_zero), int'(exp_z[got]));
        end
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk("R3", "iss_valid held before ready", int'(iss_valid), 1);
        end
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        cmp_valid = 1'b1;
        cmp_exc   = (got == exc_at);
        cmp_zero  = (got == zero_at);
        @(negedge clk);
        cmp_valid = 1'b0; cmp_exc = 1'b0; cmp_zero = 1'b0;
        got++;
      end else begin
        @(negedge clk);
        cyc++;
        if (cyc > 5000) begin
          chk(tag, "loop did not end", 0, 1);
          fin = 1;
        end
      end
    end
    chk(tag, "issue count", got, exp_n);
    chk(tag, "done", int'(done), int'(exp_done));
    chk(tag, "trap", int'(trap), int'(exp_trap));
    check_state(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired: got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "iss_valid", int'(iss_valid), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "trap", int'(trap), 0);
    check_state("R1");

    // R2 clamping
    set_vl(0, "R2");
    set_vl(31, "R2");
    set_vl(8, "R2");

    // plain loop, scalar rs2
    run_instr("R3 R4 R8", 0, 3'b011, 10, 40, 5, 16'hFFFF, 0, 0, -1, -1);
    // sub-element order
    set_vl(4, "R2");
    run_instr("R3 R4", 2, 3'b101, 20, 30, 50, 16'hFFFF, 0, 0, -1, -1);
    // skipping in non-zeroing mode, with fail-first not testing skipped elements
    set_vl(6, "R2");
    run_instr("R5", 0, 3'b111, 1, 2, 3, 16'b0000_0000_0010_0101, 0, 1, -1, -1);
    run_instr("R5 R8", 1, 3'b001, 8, 0, 0, 16'b0000_0000_0000_0011, 0, 0, -1, -1);
    // zeroing mode
    run_instr("R6", 1, 3'b001, 64, 0, 0, 16'b0000_0000_0000_1010, 1, 0, -1, -1);
    // exception and resume inside an element
    set_vl(8, "R2");
    run_instr("R7", 1, 3'b011, 30, 60, 0, 16'hFFFF, 0, 0, 5, -1);
    run_instr("R7", 1, 3'b011, 30, 60, 0, 16'hFFFF, 0, 0, -1, -1);
    // fail-first truncation
    run_instr("R9", 0, 3'b001, 4, 0, 0, 16'hFFFF, 0, 1, -1, 3);
    set_vl(8, "R2");
    run_instr("R9", 0, 3'b001, 4, 0, 0, 16'hFFFF, 0, 1, -1, 0);
    // fail-first with zeroing
    run_instr("R10", 0, 3'b001, 4, 0, 0, 16'b0000_0000_1111_1011, 1, 1, -1, -1);
    set_vl(8, "R2");
    run_instr("R10", 0, 3'b001, 4, 0, 0, 16'hFFFE, 1, 1, -1, -1);
    // offset loading and clamping
    set_vl(4, "R2");
    load_offs(10, 0, "R11");
    run_instr("R11", 0, 3'b001, 9, 0, 0, 16'hFFFF, 0, 0, -1, -1);
    load_offs(1, 3, "R11");
    run_instr("R11", 1, 3'b001, 9, 0, 0, 16'hFFFF, 0, 0, -1, -1);
    // register number wrap
    set_vl(16, "R2");
    run_instr("R4", 3, 3'b111, 120, 100, 127, 16'hFFFF, 0, 0, -1, -1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int sv, ea, za;
      bit [15:0] m;
      if ($urandom % 4 == 0) set_vl(1 + ($urandom % 16), "R2");
      sv = $urandom % 4;
      m  = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
      ea = ($urandom % 5 == 0) ? int'($urandom % 8) : -1;
      za = ($urandom % 3 == 0) ? int'($urandom % 10) : -1;
      run_instr("R3 R4 R5 R6 R7 R9 R10", sv, 3'($urandom), int'($urandom % 128),
                int'($urandom % 128), int'($urandom % 128), m, 1'($urandom),
                1'($urandom), ea, za);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule